// File: doc/BRIEF.md
# Four-Way Sign Classifier with Skip Count and Diminished Magnitude

This block carries out a count-and-skip branch step on a 15-bit ones'-complement word. Each accepted operand is sorted into one of four classes: strictly positive, plus zero (all bits clear), strictly negative, or minus zero (all bits set). The block reports how many instructions the program counter should jump over: 0, 1, 2 or 3.

In the same step the block forms a replacement accumulator value. This value is the operand's magnitude reduced by one. In ones'-complement the magnitude of a negative word is its bitwise inverse. Taking one away from a magnitude of zero wraps to minus zero.

An operand is presented together with a one-cycle strobe. On the next clock edge the skip count and the new accumulator value appear together with a one-cycle done pulse. Both stay on the outputs until the next strobe. A program-counter unit adds the skip count to its next address; fetch and decode sit outside this block.

Top module: `cskip_unit`

## Requirements
- R1: An operand with bit 14 clear and at least one other bit set gives skip count 0.
- R2: The all-zeros operand (plus zero) gives skip count 1.
- R3: An operand with bit 14 set and at least one bit clear gives skip count 2.
- R4: The all-ones operand 0x7FFF (minus zero) gives skip count 3.
- R5: For a nonzero operand, the result is its magnitude minus one. The magnitude is the word itself when bit 14 is clear, and its bitwise complement when bit 14 is set. An operand of magnitude one therefore gives 0x0000.
- R6: For either zero operand (0x0000 or 0x7FFF), the result is minus zero, 0x7FFF.
- R7: done is high in exactly the cycle after each cycle in which op_valid is high. skip_cnt and acc_next carry that operand's answer in that same cycle. Back-to-back strobes give back-to-back answers.
- R8: While rst is high and after its release, done, skip_cnt and acc_next read 0 until the first strobe is taken.
- R9: In a cycle without a strobe, skip_cnt and acc_next keep their previous values, whatever is on op_word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | One-cycle strobe marking op_word as an operand to process |
| op_word | input | 15 | Ones'-complement operand, bit 14 is the sign |
| skip_cnt | output | 2 | Number of instructions to skip (0 to 3) |
| acc_next | output | 15 | Diminished magnitude that replaces the accumulator |
| done | output | 1 | One-cycle pulse marking skip_cnt and acc_next valid |

## Verification
A wrong class decision shows up on skip_cnt in the cycle right after the strobe. The cases most likely to fail are the two zero words and the words next to the sign boundary (0x3FFF, 0x4000), so each of these is driven on its own. A fault in the magnitude or decrement path shows up on acc_next in that same cycle. Wrap-around at zero and magnitude one are separate scenarios, because an error there leaves every other operand correct. A fault in the capture enable shows up one cycle later: done misses a strobe, repeats, or the outputs drift while the strobe is low. Idle cycles with a changing op_word expose this last fault.

// File: rtl/cskip_pkg.sv
package cskip_pkg;
  localparam int unsigned SKIP_W = 2;

  typedef enum logic [SKIP_W-1:0] {
    CLS_POS  = 2'd0,
    CLS_PZRO = 2'd1,
    CLS_NEG  = 2'd2,
    CLS_MZRO = 2'd3
  } sign_cls_e;
endpackage

// File: rtl/cskip_classify.sv
module cskip_classify
  import cskip_pkg::*;
#(
  parameter int unsigned W = 15
) (
  input  logic [W-1:0] word_i,
  output sign_cls_e    cls_o,
  output logic [3:0]   flags_o
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ALL_ZERO = '0;

  logic is_pzro, is_mzro, is_pos, is_neg;

  function automatic sign_cls_e pick_class(input logic [W-1:0] w);
    if (w == ALL_ZERO)      return CLS_PZRO;
    else if (w == ALL_ONES) return CLS_MZRO;
    else if (w[W-1])        return CLS_NEG;
    else                    return CLS_POS;
  endfunction

  assign is_pzro = (word_i == ALL_ZERO);
  assign is_mzro = &word_i;
  assign is_pos  = !word_i[W-1] && !is_pzro;
  assign is_neg  = word_i[W-1] && !is_mzro;

  assign cls_o   = pick_class(word_i);
  assign flags_o = {is_mzro, is_neg, is_pzro, is_pos};

  // R1
  always_comb begin
    if (!$isunknown(word_i)) begin
      one_class_chk: assert ($onehot(flags_o))
        else $error("class flags not one-hot");
    end
  end
endmodule

// File: rtl/cskip_diminish.sv
module cskip_diminish #(
  parameter int unsigned W = 15
) (
  input  logic [W-1:0] word_i,
  output logic [W-1:0] mag_o,
  output logic [W-1:0] dim_o
);
  localparam logic [W-1:0] MINUS_ZERO = {W{1'b1}};
  localparam logic [W-1:0] ONE        = W'(1);

  function automatic logic [W-1:0] ones_abs(input logic [W-1:0] w);
    return w[W-1] ? ~w : w;
  endfunction

  function automatic logic [W-1:0] ones_dec(input logic [W-1:0] m);
    // Subtracting one from zero in ones' complement yields minus zero.
    return (m == '0) ? MINUS_ZERO : (m - ONE);
  endfunction

  assign mag_o = ones_abs(word_i);
  assign dim_o = ones_dec(mag_o);

  // R5
  always_comb begin
    if (!$isunknown(word_i)) begin
      mag_nonneg_chk: assert (mag_o[W-1] == 1'b0)
        else $error("magnitude has sign bit set");
    end
  end
endmodule

// File: rtl/cskip_unit.sv
module cskip_unit
  import cskip_pkg::*;
#(
  parameter int unsigned W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [W-1:0]      op_word,
  output logic [SKIP_W-1:0] skip_cnt,
  output logic [W-1:0]      acc_next,
  output logic              done
);
  localparam logic [W-1:0] MINUS_ZERO = {W{1'b1}};

  sign_cls_e   cls_w;
  logic [3:0]  flags_w;
  logic [W-1:0] mag_w;
  logic [W-1:0] dim_w;

  cskip_classify #(.W(W)) u_classify (
    .word_i  (op_word),
    .cls_o   (cls_w),
    .flags_o (flags_w)
  );

  cskip_diminish #(.W(W)) u_diminish (
    .word_i (op_word),
    .mag_o  (mag_w),
    .dim_o  (dim_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      skip_cnt <= '0;
      acc_next <= '0;
      done     <= 1'b0;
    end else begin
      done <= op_valid;
      if (op_valid) begin
        skip_cnt <= SKIP_W'(cls_w);
        acc_next <= dim_w;
      end
    end
  end

  // R7
  done_follows_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> done);

  // R7
  no_stray_done_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !done);

  // R1
  pos_noskip_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_word[W-1] && (op_word != '0)) |=> (skip_cnt == 2'd0));

  // R4
  mzero_skip3_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_word == MINUS_ZERO)) |=> (skip_cnt == 2'd3));

  // R6
  zero_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && ((op_word == '0) || (op_word == MINUS_ZERO))) |=> (acc_next == MINUS_ZERO));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(skip_cnt) && $stable(acc_next)));
endmodule

// File: tb/cskip_unit_bench.sv
module cskip_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [14:0] op_word;
  logic [1:0]  skip_cnt;
  logic [14:0] acc_next;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cskip_unit u_cskip_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_word(op_word),
    .skip_cnt(skip_cnt), .acc_next(acc_next), .done(done)
  );

  // Reference model from the requirements: signed value, then skip and result.
  function automatic int ref_value(input logic [14:0] w);
    int v;
    v = int'(w);
    if (w >= 15'h4000) v = -int'(15'h7FFF - w);
    return v;
  endfunction

  function automatic logic [1:0] ref_skip(input logic [14:0] w);
    if (w == 15'h0000) return 2'd1;
    if (w == 15'h7FFF) return 2'd3;
    return (ref_value(w) > 0) ? 2'd0 : 2'd2;
  endfunction

  function automatic logic [14:0] ref_result(input logic [14:0] w);
    int v;
    v = ref_value(w);
    if (v < 0) v = -v;
    if (v == 0) return 15'h7FFF;
    return 15'(v - 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one strobe and check the answer in the following cycle.
  task automatic run_one(input string req, input logic [14:0] w);
    @(negedge clk);
    op_valid = 1'b1;
    op_word  = w;
    @(negedge clk);
    op_valid = 1'b0;
    op_word  = ~w;
    check({req, " done"}, 32'(done), 32'd1);
    check({req, " skip"}, 32'(skip_cnt), 32'(ref_skip(w)));
    check({req, " result"}, 32'(acc_next), 32'(ref_result(w)));
    @(negedge clk);
    check("R7 done single pulse", 32'(done), 32'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1; op_valid = 1'b0; op_word = 15'h1234;
    repeat (3) @(negedge clk);
    check("R8 done in reset", 32'(done), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 done after reset", 32'(done), 32'd0);
    check("R8 skip after reset", 32'(skip_cnt), 32'd0);
    check("R8 result after reset", 32'(acc_next), 32'd0);
  endtask

  task automatic t_positive();
    run_one("R1 pos 5", 15'h0005);
    run_one("R1 pos max", 15'h3FFF);
    run_one("R1 R5 pos 0x1000", 15'h1000);
  endtask

  task automatic t_plus_zero();
    run_one("R2 R6 plus zero", 15'h0000);
    check("R6 plus zero wraps", 32'(acc_next), 32'h7FFF);
  endtask

  task automatic t_negative();
    run_one("R3 neg -5", 15'h7FFA);
    run_one("R3 neg most negative", 15'h4000);
    run_one("R3 R5 neg 0x5555", 15'h5555);
  endtask

  task automatic t_minus_zero();
    run_one("R4 R6 minus zero", 15'h7FFF);
    check("R4 skip three", 32'(skip_cnt), 32'd3);
  endtask

  task automatic t_magnitude_one();
    run_one("R5 plus one", 15'h0001);
    check("R5 plus one gives plus zero", 32'(acc_next), 32'h0000);
    run_one("R5 minus one", 15'h7FFE);
    check("R5 minus one gives plus zero", 32'(acc_next), 32'h0000);
  endtask

  task automatic t_hold();
    run_one("R9 setup", 15'h0123);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      op_word = 15'(i * 15'h1111 + 7);
    end
    check("R9 skip held", 32'(skip_cnt), 32'(ref_skip(15'h0123)));
    check("R9 result held", 32'(acc_next), 32'h0122);
    check("R9 no done while idle", 32'(done), 32'd0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    op_valid = 1'b1; op_word = 15'h7FFF;
    @(negedge clk);
    op_word = 15'h0002;
    check("R7 b2b first done", 32'(done), 32'd1);
    check("R7 b2b first skip", 32'(skip_cnt), 32'd3);
    check("R7 b2b first result", 32'(acc_next), 32'h7FFF);
    @(negedge clk);
    op_valid = 1'b0;
    check("R7 b2b second done", 32'(done), 32'd1);
    check("R7 b2b second skip", 32'(skip_cnt), 32'd0);
    check("R7 b2b second result", 32'(acc_next), 32'h0001);
    @(negedge clk);
    check("R7 b2b done drops", 32'(done), 32'd0);
  endtask

  initial begin
    t_reset();
    t_positive();
    t_plus_zero();
    t_negative();
    t_minus_zero();
    t_magnitude_one();
    t_hold();
    t_back_to_back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule